// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two N-bit two's complement operands and returns their exact 2N-bit two's complement product. It takes one cycle per multiplier bit and reuses a single 2N-bit adder with an accumulating register. The block does not build a combinational adder tree.

A one-cycle `start` pulse, given while the block is idle, captures both operands. `busy` then stays high for exactly N cycles. In each of those cycles one term is added into the running sum, starting from the least significant multiplier bit. For a multiplier bit of 0 the term is zero. For a multiplier bit of 1 the term is the multiplicand, sign-extended to 2N bits and shifted left by that bit's position. The term for the multiplier's top bit is negated before it is added, because that bit carries a weight of -2^(N-1). Carries out of the 2N-bit sum are dropped. As a result, neither operand ever has to be made positive, and no sign correction is needed at the end.

`done` pulses for one clock in the cycle after the last step. The product then holds until the next accepted start. The control pins are plain levels and pulses: the block has no back-pressure, and a start that arrives while it is busy is dropped.

Top module: `signed_shift_add_mul`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low and `product` is zero.
- R2: A `start` sampled high while `busy` is low captures `mcand_i` and `mplier_i`, and `busy` is high in the next cycle.
- R3: `busy` stays high for exactly N cycles after an accepted start. `done` is high for exactly one cycle, the first cycle with `busy` low again, and `done` is never high together with `busy`.
- R4: When `done` is high, `product` equals the 2N-bit two's complement product of the captured operands. For example, with N = 8, -5 times -3 gives 16'h000F.
- R5: Most-negative operands give exact results: with N = 8, -128 times -128 gives 16'h4000, -128 times -1 gives 16'h0080, and 127 times -128 gives 16'hC080.
- R6: A `start` pulse while `busy` is high has no effect. Changes on the operand inputs while busy also have no effect. Both the timing and the result are those of the operation already running.
- R7: While idle, `product` holds its last value until the next accepted start.
- R8: A `start` given in the same cycle that `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, honoured only while idle |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement |
| busy | output | 1 | High during the N accumulate cycles |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | Two's complement product, 2N bits |

## Verification
The bench targets the operands at the edges of the range: the most negative value times itself, times -1, and times the most positive value, plus negative-times-negative cases such as -5 times -3. If the top-bit term were added instead of subtracted, these cases would come out with the wrong sign or off by 2^N. If the multiplicand were not sign-extended, the upper half of the product would be wrong. The bench also fires `start` while busy, with new operands on the inputs. A design that re-armed on that pulse, or read the live inputs, would return the wrong product or stretch `busy`. Finally, the bench starts a new operation in the `done` cycle, which catches an FSM that takes an extra cycle to return to idle.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   launch,
  output logic [$clog2(N)-1:0]   step_idx,
  output logic                   last_step
);
  import smul_pkg::*;
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  smul_state_e state_q;
  logic [CW-1:0] idx_q;
  logic done_q;

  assign busy      = (state_q == SM_RUN);
  assign launch    = start && (state_q == SM_IDLE);
  assign step_idx  = idx_q;
  assign last_step = busy && (idx_q == LAST_IDX);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SM_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SM_IDLE: begin
          if (start) begin
            state_q <= SM_RUN;
            idx_q   <= '0;
          end
        end
        SM_RUN: begin
          if (idx_q == LAST_IDX) begin
            state_q <= SM_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SM_IDLE;
      endcase
    end
  end

  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);
  // R3
  run_continue_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> busy);
  // R3
  finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    last_step |=> (done && !busy));
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last_step) |=> (busy && !done));
endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
  parameter int N = 8
) (
  input  logic [N-1:0]           mcand,
  input  logic                   bit_set,
  input  logic                   neg_weight,
  input  logic [$clog2(N)-1:0]   shift,
  output logic [2*N-1:0]         term
);
  localparam int W = 2 * N;
  logic [W-1:0] ext;
  logic [W-1:0] shifted;

  assign ext     = {{N{mcand[N-1]}}, mcand};
  assign shifted = ext << shift;

  always_comb begin
    if (!bit_set)        term = '0;
    else if (neg_weight) term = (~shifted) + 1'b1;
    else                 term = shifted;
  end
endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           add_en,
  input  logic [2*N-1:0] term,
  output logic [2*N-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (clear)  acc <= '0;
    else if (add_en) acc <= acc + term;
  end

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !add_en) |=> $stable(acc));
  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == '0));
endmodule

// File: rtl/signed_shift_add_mul.sv
module signed_shift_add_mul #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N-1:0]     mcand_i,
  input  logic [N-1:0]     mplier_i,
  output logic             busy,
  output logic             done,
  output logic [2*N-1:0]   product
);
  localparam int CW = $clog2(N);

  logic          launch;
  logic          last_step;
  logic [CW-1:0] step_idx;
  logic [N-1:0]  mcand_q;
  logic [N-1:0]  mplier_q;
  logic [2*N-1:0] term;

  smul_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .launch(launch),
    .step_idx(step_idx), .last_step(last_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (launch) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
    end
  end

  smul_ppgen #(.N(N)) u_ppgen (
    .mcand(mcand_q),
    .bit_set(mplier_q[step_idx]),
    .neg_weight(last_step),
    .shift(step_idx),
    .term(term)
  );

  smul_accum #(.N(N)) u_accum (
    .clk(clk), .rst(rst), .clear(launch),
    .add_en(busy), .term(term), .acc(product)
  );

  // R6
  operands_held_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> ($stable(mcand_q) && $stable(mplier_q)));
endmodule

// File: tb/signed_shift_add_mul_test.sv
`timescale 1ns/1ps
module signed_shift_add_mul_test;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N-1:0] mcand_i = '0;
  logic [N-1:0] mplier_i = '0;
  logic busy, done;
  logic [W-1:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  logic [W-1:0] m_prod = '0, m_pend = '0;

  always #2 clk = ~clk;

  signed_shift_add_mul #(.N(N)) uut (
    .clk(clk), .rst(rst), .start(start),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [W-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    longint pa, pb, pr;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pr = pa * pb;
    return pr[W-1:0];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        m_busy = 1; m_cnt = 0; m_prod = '0;
        m_pend = ref_mul(mcand_i, mplier_i);
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == N) begin
          m_busy = 0; m_done = 1; m_prod = m_pend;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 busy", W'(busy), W'(m_busy));
      chk("R3 done", W'(done), W'(m_done));
      if (!m_busy) chk("R7 product", product, m_prod);
    end
  end

  task automatic launch(logic [N-1:0] a, logic [N-1:0] b);
    @(negedge clk);
    start = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", W'(busy), W'(1));
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_op(string tag, logic [N-1:0] a, logic [N-1:0] b, logic [W-1:0] exp);
    launch(a, b);
    wait_done();
    chk(tag, product, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", W'(busy), W'(0));
    chk("R1 done", W'(done), W'(0));
    chk("R1 product", product, '0);
    rst = 1'b0;
    @(negedge clk);

    run_op("R4 -5*-3", 8'hFB, 8'hFD, 16'h000F);
    run_op("R4 0*x", 8'h00, 8'h9C, 16'h0000);
    run_op("R4 7*-9", 8'h07, 8'hF7, ref_mul(8'h07, 8'hF7));
    run_op("R5 min*min", 8'h80, 8'h80, 16'h4000);
    run_op("R5 min*-1", 8'h80, 8'hFF, 16'h0080);
    run_op("R5 -1*min", 8'hFF, 8'h80, 16'h0080);
    run_op("R5 max*min", 8'h7F, 8'h80, 16'hC080);

    // R6: start while busy with different operands on the pins
    launch(8'h03, 8'h05);
    @(negedge clk);
    start = 1'b1; mcand_i = 8'h64; mplier_i = 8'hF9;
    @(negedge clk);
    start = 1'b0; mcand_i = 8'h11; mplier_i = 8'h22;
    wait_done();
    chk("R6 result unchanged", product, 16'h000F);

    // R7: idle hold for several cycles
    repeat (5) @(negedge clk);
    chk("R7 hold", product, 16'h000F);

    // R8: start in the done cycle
    launch(8'h0C, 8'hFE);
    wait_done();
    start = 1'b1; mcand_i = 8'hF0; mplier_i = 8'h10;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start in done cycle", W'(busy), W'(1));
    wait_done();
    chk("R8 product", product, ref_mul(8'hF0, 8'h10));

    // R4: pseudo-random patterns
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 40; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        run_op("R4 pattern", lf[7:0], lf[15:8], ref_mul(lf[7:0], lf[15:8]));
      end
    end

    // R1: reset mid-run
    launch(8'h55, 8'hAA);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", W'(busy), W'(0));
    chk("R1 product after reset", product, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cycles > 100000) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule